// File: doc/BRIEF.md
# ROM Image Checksum Verifier

This block checks a bank of byte-wide ROM images, one socket after another, through a synchronous read port. For each socket it first looks at a presence signature in the header: a suffix byte and the byte beside it must be bitwise complements. If they are not, the socket counts as empty and the block moves on without summing it. A present ROM must carry its own socket number in its header, or it is reported as misplaced. The block then folds every byte from index 2 to the end of the image into a 16-bit rotate-and-add accumulator and compares the result with the checksum stored in the header.

Each socket produces one result strobe carrying the socket number and an outcome code. The first bad or misplaced ROM halts the walk and starts an error indicator that blinks socket+1 times per train. If every socket passes, a pass indicator is lit. It stays on without blinking when no socket was empty, and otherwise blinks once per empty socket in each train. A run is started by a `start` pulse after reset. The block stays halted in its final state until the next reset.

Top module: `rom_hdr_verifier`

## Requirements
- R1: After reset, `resValid`, `done`, `failed`, `errLed` and `passLed` are 0 and `emptyCnt` is 0.
- R2: A socket whose header bytes at index 4 and index 5 are not bitwise complements gets code 3 (absent), and `emptyCnt` goes up by one. Its checksum is not evaluated, so a wrong stored sum in that socket has no effect, and the walk continues.
- R3: For a present socket, if the header byte at index 3 differs from the socket number, the result is code 2 (misplaced) and the walk halts with `failed` = 1.
- R4: The checksum starts at 0. For each byte at index 2 up to the last index, in ascending order, the accumulator is rotated left by one bit and the zero-extended byte is then added modulo 2^16. A result that differs from {byte0, byte1} (byte 0 most significant) gives code 1 (bad) and the walk halts with `failed` = 1.
- R5: A present, correctly placed ROM with a matching sum gives code 0 (good). Sockets report in ascending order from 0, one strobe each, and no two strobes fall in adjacent cycles.
- R6: After a failure no further result strobes appear, and `done` and `failed` hold until reset.
- R7: After a failure at socket N, `errLed` repeats trains of N+1 pulses. Each pulse is high for PULSE_LEN cycles and low for PULSE_LEN cycles, and trains are separated by GAP_LEN low cycles. Both indicators stay dark before `done`, and they are never lit together.
- R8: When all sockets finish without error, `done` = 1 and `failed` = 0. With no empty socket, `passLed` is lit continuously from the cycle `done` rises.
- R9: On a pass with E > 0 empty sockets, `passLed` repeats trains of E pulses with the same timing as R7.
- R10: `start` has no effect once a run has begun or finished: the result sequence and the final state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the walk when idle after reset |
| rdSock | output | SOCK_W | Socket selected for the read |
| rdAddr | output | ADDR_W | Byte index within the selected image |
| rdData | input | 8 | Read data, valid one cycle after the address |
| resValid | output | 1 | One-cycle strobe carrying a socket outcome |
| resSock | output | SOCK_W | Socket the outcome belongs to |
| resCode | output | 2 | 0 good, 1 bad sum, 2 misplaced, 3 absent |
| emptyCnt | output | SOCK_W | Number of empty sockets found so far |
| done | output | 1 | Walk has ended (pass or fail) |
| failed | output | 1 | Walk ended on a bad or misplaced ROM |
| errLed | output | 1 | Error pulse-train indicator |
| passLed | output | 1 | Pass indicator, steady or pulsed |

## Verification
A corrupted accumulator or a stale stored-sum register turns a good socket's code into 1 and halts the walk at that socket. This is visible on the very next result strobe and on the pulse count of `errLed` one train later. A wrong presence comparison flips a socket between code 3 and a summed outcome, which shows both in `emptyCnt` and in the pass-train length. An off-by-one in the socket counter or the header indices misplaces every ROM from socket 0 onward, so the first strobe already reports code 2. Pulse-timer faults appear within one train period as a wrong rise count or a wrong total high time.

// File: rtl/rom_chk_pkg.sv
package rom_chk_pkg;

  localparam int ACC_W = 16;

  // header byte positions; the datapath and control both rely on these
  localparam int HDR_SUM_HI = 0;
  localparam int HDR_SUM_LO = 1;
  localparam int SUM_FIRST  = 2;
  localparam int HDR_ID     = 3;
  localparam int HDR_SUF    = 4;
  localparam int HDR_CMP    = 5;

  typedef enum logic [1:0] {
    RES_GOOD      = 2'd0,
    RES_BAD       = 2'd1,
    RES_MISPLACED = 2'd2,
    RES_ABSENT    = 2'd3
  } resCode_t;

  typedef enum logic [2:0] {
    OP_SUF, OP_CMP, OP_ID, OP_CKH, OP_CKL, OP_SUM
  } readOp_t;

  typedef struct packed {
    logic capSuf;
    logic capCmp;
    logic capId;
    logic capHi;
    logic capLo;
    logic clrAcc;
    logic stepAcc;
    logic incEmpty;
  } dpStrobe_t;

endpackage

// File: rtl/rom_chk_dp.sv
module rom_chk_dp
  import rom_chk_pkg::*;
#(
  parameter int SOCK_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        rdData,
  input  logic [SOCK_W-1:0] sock,
  output logic              presentOk,
  output logic              idOk,
  output logic              sumOk,
  output logic [SOCK_W-1:0] emptyCnt
);

  logic [7:0]       sufReg, cmpReg, idReg, sumHi, sumLo;
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sufReg   <= '0;
      cmpReg   <= '0;
      idReg    <= '0;
      sumHi    <= '0;
      sumLo    <= '0;
      acc      <= '0;
      emptyCnt <= '0;
    end else begin
      if (strobe.capSuf) sufReg <= rdData;
      if (strobe.capCmp) cmpReg <= rdData;
      if (strobe.capId)  idReg  <= rdData;
      if (strobe.capHi)  sumHi  <= rdData;
      if (strobe.capLo)  sumLo  <= rdData;
      if (strobe.clrAcc)
        acc <= '0;
      else if (strobe.stepAcc)
        acc <= {acc[ACC_W-2:0], acc[ACC_W-1]} + {{(ACC_W-8){1'b0}}, rdData};
      if (strobe.incEmpty) emptyCnt <= emptyCnt + 1'b1;
    end
  end

  assign presentOk = ((sufReg ^ cmpReg) == 8'hFF);
  assign idOk      = (idReg == 8'(sock));
  assign sumOk     = (acc == {sumHi, sumLo});

endmodule

// File: rtl/rom_chk_ctrl.sv
module rom_chk_ctrl
  import rom_chk_pkg::*;
#(
  parameter int NUM_ROMS = 18,
  parameter int IMG_LEN  = 64,
  parameter int SOCK_W   = 5,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              presentOk,
  input  logic              idOk,
  input  logic              sumOk,
  output dpStrobe_t         strobe,
  output logic [SOCK_W-1:0] sock,
  output logic [ADDR_W-1:0] addr,
  output logic              resValid,
  output logic [1:0]        resCode,
  output logic              done,
  output logic              failed
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMG_LEN - 1);
  localparam logic [SOCK_W-1:0] LAST_SOCK = SOCK_W'(NUM_ROMS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_TAKE, S_EVAL, S_FAIL, S_PASS
  } state_t;

  state_t            state, nextState;
  readOp_t           op, nextOp;
  logic [SOCK_W-1:0] nextSock;
  logic [ADDR_W-1:0] nextAddr;
  resCode_t          code;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      op    <= OP_SUF;
      sock  <= '0;
      addr  <= '0;
    end else begin
      state <= nextState;
      op    <= nextOp;
      sock  <= nextSock;
      addr  <= nextAddr;
    end
  end

  always_comb begin
    nextState = state;
    nextOp    = op;
    nextSock  = sock;
    nextAddr  = addr;
    strobe    = '0;
    resValid  = 1'b0;
    code      = RES_GOOD;
    case (state)
      S_IDLE: begin
        if (start) begin
          nextState = S_WAIT;
          nextSock  = '0;
          nextAddr  = ADDR_W'(HDR_SUF);
          nextOp    = OP_SUF;
        end
      end
      S_WAIT: nextState = S_TAKE;
      S_TAKE: begin
        case (op)
          OP_SUF: begin
            strobe.capSuf = 1'b1;
            nextAddr  = ADDR_W'(HDR_CMP);
            nextOp    = OP_CMP;
            nextState = S_WAIT;
          end
          OP_CMP: begin
            strobe.capCmp = 1'b1;
            nextState = S_EVAL;
          end
          OP_ID: begin
            strobe.capId = 1'b1;
            nextState = S_EVAL;
          end
          OP_CKH: begin
            strobe.capHi = 1'b1;
            nextAddr  = ADDR_W'(HDR_SUM_LO);
            nextOp    = OP_CKL;
            nextState = S_WAIT;
          end
          OP_CKL: begin
            strobe.capLo  = 1'b1;
            strobe.clrAcc = 1'b1;
            nextAddr  = ADDR_W'(SUM_FIRST);
            nextOp    = OP_SUM;
            nextState = S_WAIT;
          end
          default: begin
            strobe.stepAcc = 1'b1;
            if (addr == LAST_ADDR) begin
              nextState = S_EVAL;
            end else begin
              nextAddr  = addr + 1'b1;
              nextState = S_WAIT;
            end
          end
        endcase
      end
      S_EVAL: begin
        // advancing to the next socket is shared by absent and good outcomes
        if ((op == OP_CMP && !presentOk) || (op == OP_SUM && sumOk)) begin
          resValid = 1'b1;
          code     = (op == OP_CMP) ? RES_ABSENT : RES_GOOD;
          strobe.incEmpty = (op == OP_CMP);
          if (sock == LAST_SOCK) begin
            nextState = S_PASS;
          end else begin
            nextSock  = sock + 1'b1;
            nextAddr  = ADDR_W'(HDR_SUF);
            nextOp    = OP_SUF;
            nextState = S_WAIT;
          end
        end else if (op == OP_CMP) begin
          nextAddr  = ADDR_W'(HDR_ID);
          nextOp    = OP_ID;
          nextState = S_WAIT;
        end else if (op == OP_ID && idOk) begin
          nextAddr  = ADDR_W'(HDR_SUM_HI);
          nextOp    = OP_CKH;
          nextState = S_WAIT;
        end else begin
          resValid  = 1'b1;
          code      = (op == OP_ID) ? RES_MISPLACED : RES_BAD;
          nextState = S_FAIL;
        end
      end
      S_FAIL:  nextState = S_FAIL;
      S_PASS:  nextState = S_PASS;
      default: nextState = S_IDLE;
    endcase
  end

  assign resCode = code;
  assign done    = (state == S_FAIL) || (state == S_PASS);
  assign failed  = (state == S_FAIL);

endmodule

// File: rtl/rom_chk_pulse.sv
module rom_chk_pulse #(
  parameter int CNT_W     = 5,
  parameter int PULSE_LEN = 1000,
  parameter int GAP_LEN   = 4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             steady,
  input  logic [CNT_W-1:0] count,
  output logic             led
);

  localparam int MAX_LEN = (PULSE_LEN > GAP_LEN) ? PULSE_LEN : GAP_LEN;
  localparam int TIM_W   = $clog2(MAX_LEN + 1);
  localparam logic [TIM_W-1:0] P_LOAD = TIM_W'(PULSE_LEN - 1);
  localparam logic [TIM_W-1:0] G_LOAD = TIM_W'(GAP_LEN - 1);

  typedef enum logic [1:0] {PH_OFF, PH_HIGH, PH_LOW, PH_GAP} phase_t;

  phase_t           phase;
  logic [TIM_W-1:0] timer;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_OFF;
      timer <= '0;
      left  <= '0;
    end else if (!enable) begin
      phase <= PH_OFF;
      timer <= '0;
      left  <= '0;
    end else begin
      case (phase)
        PH_OFF: begin
          if (!steady && count != '0) begin
            phase <= PH_HIGH;
            timer <= P_LOAD;
            left  <= count;
          end
        end
        PH_HIGH: begin
          if (timer == '0) begin
            phase <= PH_LOW;
            timer <= P_LOAD;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        PH_LOW: begin
          if (timer != '0) begin
            timer <= timer - 1'b1;
          end else if (left == CNT_W'(1)) begin
            phase <= PH_GAP;
            timer <= G_LOAD;
          end else begin
            phase <= PH_HIGH;
            timer <= P_LOAD;
            left  <= left - 1'b1;
          end
        end
        default: begin
          if (timer == '0) begin
            phase <= PH_HIGH;
            timer <= P_LOAD;
            left  <= count;
          end else begin
            timer <= timer - 1'b1;
          end
        end
      endcase
    end
  end

  assign led = enable && (steady || phase == PH_HIGH);

endmodule

// File: rtl/rom_hdr_verifier.sv
module rom_hdr_verifier
  import rom_chk_pkg::*;
#(
  parameter int NUM_ROMS  = 18,
  parameter int IMG_LEN   = 64,
  parameter int PULSE_LEN = 1000,
  parameter int GAP_LEN   = 4000,
  localparam int SOCK_W   = $clog2(NUM_ROMS + 1),
  localparam int ADDR_W   = $clog2(IMG_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [SOCK_W-1:0] rdSock,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              resValid,
  output logic [SOCK_W-1:0] resSock,
  output logic [1:0]        resCode,
  output logic [SOCK_W-1:0] emptyCnt,
  output logic              done,
  output logic              failed,
  output logic              errLed,
  output logic              passLed
);

  dpStrobe_t         strobe;
  logic              presentOk, idOk, sumOk;
  logic [SOCK_W-1:0] sock;
  logic [SOCK_W-1:0] errCount;

  rom_chk_ctrl #(
    .NUM_ROMS(NUM_ROMS), .IMG_LEN(IMG_LEN), .SOCK_W(SOCK_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .presentOk(presentOk), .idOk(idOk), .sumOk(sumOk),
    .strobe(strobe), .sock(sock), .addr(rdAddr),
    .resValid(resValid), .resCode(resCode), .done(done), .failed(failed)
  );

  rom_chk_dp #(.SOCK_W(SOCK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData), .sock(sock),
    .presentOk(presentOk), .idOk(idOk), .sumOk(sumOk), .emptyCnt(emptyCnt)
  );

  assign errCount = SOCK_W'(sock + 1'b1);

  rom_chk_pulse #(.CNT_W(SOCK_W), .PULSE_LEN(PULSE_LEN), .GAP_LEN(GAP_LEN)) u_errPulse (
    .clk(clk), .rstN(rstN), .enable(failed), .steady(1'b0),
    .count(errCount), .led(errLed)
  );

  rom_chk_pulse #(.CNT_W(SOCK_W), .PULSE_LEN(PULSE_LEN), .GAP_LEN(GAP_LEN)) u_passPulse (
    .clk(clk), .rstN(rstN), .enable(done && !failed), .steady(emptyCnt == '0),
    .count(emptyCnt), .led(passLed)
  );

  assign rdSock  = sock;
  assign resSock = sock;

endmodule

// File: rtl/rom_chk_checker.sv
module rom_chk_checker #(
  parameter int NUM_ROMS = 18,
  parameter int SOCK_W   = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              resValid,
  input logic [SOCK_W-1:0] resSock,
  input logic [1:0]        resCode,
  input logic [SOCK_W-1:0] emptyCnt,
  input logic              done,
  input logic              failed,
  input logic              errLed,
  input logic              passLed
);

  p_result_spacing_r5: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  p_sock_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resSock < SOCK_W'(NUM_ROMS)));

  p_empty_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCode == 2'd3) |=> (emptyCnt == $past(emptyCnt) + 1'b1));

  p_fail_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (resCode == 2'd1 || resCode == 2'd2)) |=> (done && failed));

  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done && failed == $past(failed)));

  p_quiet_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !resValid);

  p_leds_dark_r7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!errLed && !passLed));

  p_led_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(errLed && passLed));

  p_last_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resSock == SOCK_W'(NUM_ROMS - 1) && (resCode == 2'd0 || resCode == 2'd3))
      |=> (done && !failed));

endmodule

bind rom_hdr_verifier rom_chk_checker #(.NUM_ROMS(NUM_ROMS), .SOCK_W(SOCK_W)) u_chk (
  .clk(clk), .rstN(rstN), .resValid(resValid), .resSock(resSock),
  .resCode(resCode), .emptyCnt(emptyCnt), .done(done), .failed(failed),
  .errLed(errLed), .passLed(passLed)
);

// File: tb/sim_rom_hdr_verifier.sv
`timescale 1ns/1ps
module sim_rom_hdr_verifier;

  localparam int NUM  = 18;
  localparam int LEN  = 16;
  localparam int PL   = 2;
  localparam int GL   = 6;
  localparam int NSC  = 7;

  // scenario vector: {absent mask[17:0], fault socket[4:0], fault kind[1:0]}
  // kind 0 none, 1 bad stored sum, 2 wrong id byte
  localparam logic [24:0] SCEN [NSC] = '{
    {18'h00000, 5'd0,  2'd0},
    {18'h20022, 5'd0,  2'd0},
    {18'h00000, 5'd3,  2'd1},
    {18'h00000, 5'd0,  2'd2},
    {18'h00004, 5'd17, 2'd1},
    {18'h00001, 5'd6,  2'd2},
    {18'h3FFFF, 5'd0,  2'd0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [4:0] rdSock;
  logic [3:0] rdAddr;
  logic [7:0] rdData;
  logic       resValid;
  logic [4:0] resSock;
  logic [1:0] resCode;
  logic [4:0] emptyCnt;
  logic       done, failed, errLed, passLed;

  logic [7:0] mem [NUM][LEN];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) rdData <= mem[rdSock][rdAddr];

  rom_hdr_verifier #(.NUM_ROMS(NUM), .IMG_LEN(LEN), .PULSE_LEN(PL), .GAP_LEN(GL)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .rdSock(rdSock), .rdAddr(rdAddr),
    .rdData(rdData), .resValid(resValid), .resSock(resSock), .resCode(resCode),
    .emptyCnt(emptyCnt), .done(done), .failed(failed), .errLed(errLed), .passLed(passLed)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] spiral(input int s);
    logic [15:0] a = 16'h0000;
    for (int i = 2; i < LEN; i++) a = {a[14:0], a[15]} + {8'h00, mem[s][i]};
    return a;
  endfunction

  task automatic buildImages(input logic [17:0] absentMask, input int fs, input int kind);
    logic [15:0] sum;
    for (int s = 0; s < NUM; s++) begin
      for (int i = 0; i < LEN; i++) mem[s][i] = 8'((s * 31 + i * 13 + 7) & 255);
      mem[s][3] = 8'(s);
      mem[s][4] = 8'(s * 7 + 1);
      mem[s][5] = ~mem[s][4];
      if (s == 9) begin mem[s][4] = 8'h00; mem[s][5] = 8'hFF; end
      if (kind == 2 && s == fs) mem[s][3] = 8'(s + 1);
      if (absentMask[s]) mem[s][5] = mem[s][4];
      sum = spiral(s);
      mem[s][0] = sum[15:8];
      mem[s][1] = sum[7:0];
      if (kind == 1 && s == fs) mem[s][1] = mem[s][1] ^ 8'h01;
      if (absentMask[s]) mem[s][0] = mem[s][0] ^ 8'h80; // R2: sum must not matter
    end
  endtask

  task automatic runScen(input int idx);
    logic [24:0] v;
    logic [17:0] absentMask;
    int fs, kind, expCount, empties, got, cyc, failSock, window, rises, highs, strays;
    bit expFail, prevLed, led;
    int expCode [NUM];
    v = SCEN[idx];
    absentMask = v[24:7];
    fs = int'(v[6:2]);
    kind = int'(v[1:0]);

    // expected outcome from the rules alone
    expCount = 0; empties = 0; expFail = 0; failSock = 0;
    for (int s = 0; s < NUM; s++) begin
      if (absentMask[s]) begin expCode[s] = 3; empties++; end
      else if (kind == 2 && s == fs) expCode[s] = 2;
      else if (kind == 1 && s == fs) expCode[s] = 1;
      else expCode[s] = 0;
      expCount++;
      if (expCode[s] == 1 || expCode[s] == 2) begin expFail = 1; failSock = s; break; end
    end

    buildImages(absentMask, fs, kind);
    rstN = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!resValid && !done && !failed && !errLed && !passLed, "R1 idle outputs", int'({resValid, done, failed, errLed, passLed}), 0);
    check(emptyCnt == 0, "R1 emptyCnt", int'(emptyCnt), 0);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      start = (cyc == 10); // R10: a second start mid-run changes nothing
      if (resValid) begin
        if (got < NUM) begin
          check(int'(resSock) == got, "R5 socket order", int'(resSock), got);
          check(int'(resCode) == expCode[got],
                expCode[got] == 3 ? "R2 absent code" : expCode[got] == 2 ? "R3 misplaced code" :
                expCode[got] == 1 ? "R4 bad sum code" : "R5 good code", int'(resCode), expCode[got]);
        end
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done, "R6 done reached", int'(done), 1);
    check(got == expCount, "R6 result count", got, expCount);
    check(failed == expFail, expFail ? "R6 failed flag" : "R8 failed flag", int'(failed), int'(expFail));
    check(int'(emptyCnt) == empties, "R2 empty count", int'(emptyCnt), empties);

    if (!expFail && empties == 0)
      check(passLed, "R8 steady pass at done", int'(passLed), 1);

    // observe one train period; also pulse start (R10) and watch for strays (R6)
    if (expFail) window = (failSock + 1) * 2 * PL + GL;
    else if (empties > 0) window = empties * 2 * PL + GL;
    else window = 20;
    prevLed = expFail ? errLed : passLed;
    rises = 0; highs = 0; strays = 0;
    for (int c = 0; c < window; c++) begin
      start = (c == 0);
      @(negedge clk);
      led = expFail ? errLed : passLed;
      if (led && !prevLed) rises++;
      if (led) highs++;
      if (resValid || !done) strays++;
      if (expFail ? passLed : errLed) strays++;
      prevLed = led;
    end
    start = 1'b0;
    check(strays == 0, "R10 no activity after done", strays, 0);
    if (expFail) begin
      check(rises == failSock + 1, "R7 error pulses", rises, failSock + 1);
      check(highs == (failSock + 1) * PL, "R7 error high time", highs, (failSock + 1) * PL);
    end else if (empties > 0) begin
      check(rises == empties, "R9 pass pulses", rises, empties);
      check(highs == empties * PL, "R9 pass high time", highs, empties * PL);
    end else begin
      check(highs == window, "R8 pass steady", highs, window);
    end
  endtask

  initial begin
    for (int k = 0; k < NSC; k++) runScen(k);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule